// File: doc/BRIEF.md
# Continuous Conversion Start Sequencer

This block sits between a free-form start request and an analog-to-digital converter that reports its state on an end-of-conversion line (low while busy, high when done). A request of any length, as long as it is shorter than one conversion, is captured in a request latch and turned into a start pulse exactly one clock wide. After each start, a small binary counter is preloaded and held until the converter has gone busy and then signalled end-of-conversion. From then on it counts up on every clock where end-of-conversion is high. When the count reaches its top value, the carry produces a one-clock ready pulse. That pulse says the result has settled in the converter's output latch and a new cycle may begin. The carry also clears the request latch.

The request input may change at any time, so it passes through a synchronizer before it reaches the latch. If the request is held high, the latch is set again right after each ready pulse, and the converter runs back to back without further action.

Top module: `conv_start_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the request latch, counter and phase are cleared. conv_start and ready are low in the following cycle, and no start occurs afterwards unless a new request arrives.
- R2: start_req passes through SYNC_STAGES flip-flops (default 2). A request high at one clock edge is seen by the request latch SYNC_STAGES edges later, and a single-cycle request is enough to set the latch.
- R3: conv_start is high for exactly one clock cycle. It rises on the edge after which the latch is set while no conversion is in progress.
- R4: On the edge that raises conv_start, the counter is loaded with PRELOAD (default 11). It then holds until eoc has been sampled low once.
- R5: After eoc has been sampled low, the counter increments on every edge where eoc is sampled high and holds on every edge where eoc is sampled low.
- R6: ready is high for exactly one cycle, when the count equals its all-ones value (15 with the default 4-bit width). This is the fourth edge on which eoc is sampled high after the conversion went busy.
- R7: The edge after ready clears the request latch. A synchronized request arriving on that same edge loses to the clear.
- R8: A request that arrives while a conversion is in progress sets no second start for that conversion. Requests arriving during an active conversion are absorbed by the already-set latch.
- R9: With start_req held high, conversions repeat: each ready is followed by a new conversion start without any further edge on start_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Conversion request, asynchronous, any length |
| eoc | input | 1 | Converter end-of-conversion (low = busy) |
| conv_start | output | 1 | One-clock start pulse to the converter |
| ready | output | 1 | One-clock pulse: result latched, new cycle allowed |

## Verification
A single one-clock request checks the basic path: synchronizer latency, start pulse width, and the four-edge delay from eoc high to ready. A second request placed inside a running conversion, swept across every offset, separates absorbed requests from restarts, including the case where the request meets the latch clear. A held request checks back-to-back operation. A converter that briefly drops eoc during the count window shows that counting pauses rather than restarts, and a reset in mid-conversion shows that no late ready escapes.

// File: rtl/conv_seq_pkg.sv
// Package: shared phase encoding for the conversion start sequencer.
// Assumes: imported by the counter module and the top.
package conv_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // no conversion in flight
        PH_ARMED = 2'd1,   // start sent, waiting for converter to go busy
        PH_RUN   = 2'd2    // busy seen, counting on eoc high
    } seq_phase_e;
endpackage

// File: rtl/conv_req_sync.sv
// Module: conv_req_sync
// Brings the asynchronous request into the clock domain through a chain
// of STAGES flip-flops. Assumes STAGES >= 1; reset clears the chain.
module conv_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the request.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_in;
            end
        end else begin : g_multi
            // Shift the request through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/conv_req_latch.sv
// Module: conv_req_latch
// Set/clear request latch. Clear dominates set. Assumes both inputs are
// synchronous to clk.
module conv_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;

    // Hold a pending request until the sequencer's carry clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (clr_i) pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
    end

    assign pend_o = pend_q;

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_o)
        else $error("request latch survived a clear");

    p_set_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> pend_o)
        else $error("request latch missed a set");
endmodule

// File: rtl/conv_seq_counter.sv
// Module: conv_seq_counter
// Issues the one-clock start, preloads the counter, waits for the converter
// to go busy, counts eoc-high edges, and raises carry at all-ones.
// Assumes eoc is synchronous to clk.
module conv_seq_counter
    import conv_seq_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int PRELOAD = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eoc_i,
    output logic start_o,
    output logic carry_o
);
    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PRELOAD);

    seq_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_q;

    assign carry_o = (phase_q == PH_RUN) && (cnt_q == CNT_TOP);
    assign start_o = start_q;

    // Phase, counter and start-pulse sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (pend_i) begin
                        start_q <= 1'b1;
                        cnt_q   <= CNT_LOAD;
                        phase_q <= PH_ARMED;
                    end
                end
                PH_ARMED: begin
                    if (!eoc_i) phase_q <= PH_RUN;
                end
                PH_RUN: begin
                    if (cnt_q == CNT_TOP) phase_q <= PH_IDLE;
                    else if (eoc_i)       cnt_q   <= cnt_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    p_start_one_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o)
        else $error("start pulse longer than one clock");

    p_preload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (cnt_q == CNT_LOAD && phase_q == PH_ARMED))
        else $error("counter not preloaded at start");

    p_hold_on_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN && !eoc_i) |=> $stable(cnt_q))
        else $error("counter moved while eoc low");

    p_carry_one_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> !carry_o)
        else $error("carry longer than one clock");

    p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> !start_o)
        else $error("start issued during conversion");
endmodule

// File: rtl/conv_start_seq.sv
// Module: conv_start_seq (top)
// Turns an asynchronous start request into one-clock converter starts and
// reports a ready pulse a fixed number of eoc-high clocks after each
// conversion ends. Assumes eoc is synchronous to clk; reset is synchronous,
// active low.
module conv_start_seq #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4,
    parameter int PRELOAD     = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic eoc,
    output logic conv_start,
    output logic ready
);
    logic req_s;
    logic pend;
    logic carry;

    conv_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (start_req),
        .q_out (req_s)
    );

    conv_req_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (req_s),
        .clr_i  (carry),
        .pend_o (pend)
    );

    conv_seq_counter #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pend),
        .eoc_i   (eoc),
        .start_o (conv_start),
        .carry_o (carry)
    );

    assign ready = carry;

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!conv_start && !ready))
        else $error("outputs active after reset");

    p_ready_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(conv_start && ready))
        else $error("start and ready together");
endmodule

// File: tb/test_conv_start_seq.sv
// Bench: behavioural reference model compared every clock, plus a simple
// converter model driving eoc.
module test_conv_start_seq;
    localparam int SYNC = 2;
    localparam int GAP  = 4;   // eoc-high edges from busy end to ready

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic eoc = 1'b1;
    logic conv_start, ready;

    int n_chk = 0, n_fail = 0;
    int n_start = 0, n_ready = 0;
    int conv_len = 12;
    bit glitch_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    conv_start_seq i_conv_start_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .eoc(eoc),
        .conv_start(conv_start), .ready(ready)
    );

    // converter model: busy for conv_len clocks, optional eoc dip
    int cv = 0, hi_age = 0, dip = 0;
    always @(posedge clk) begin
        if (conv_start) begin
            cv = conv_len; eoc <= 1'b0; hi_age = 0;
        end else if (cv > 0) begin
            cv--;
            if (cv == 0) eoc <= 1'b1;
        end else if (dip > 0) begin
            dip--;
            if (dip == 0) eoc <= 1'b1;
        end else begin
            hi_age++;
            if (glitch_en && hi_age == 2) begin eoc <= 1'b0; dip = 2; end
        end
    end

    // reference model
    bit sq[$];
    bit m_pend = 0, m_start = 0;
    int m_mode = 0;            // 0 idle, 1 armed, 2 run
    int m_left = 0;
    bit m_carry;
    always @(posedge clk) begin
        bit rs, c_now, p_old;
        if (!rst_n) begin
            sq.delete();
            for (int i = 0; i < SYNC; i++) sq.push_back(1'b0);
            m_pend = 0; m_start = 0; m_mode = 0; m_left = 0;
        end else begin
            rs = sq.pop_front();
            sq.push_back(start_req);
            c_now = (m_mode == 2 && m_left == 0);
            p_old = m_pend;
            m_pend = c_now ? 1'b0 : (m_pend | rs);
            m_start = (m_mode == 0 && p_old);
            if (c_now) m_mode = 0;
            else if (m_mode == 0 && p_old) begin m_mode = 1; m_left = GAP; end
            else if (m_mode == 1 && !eoc) m_mode = 2;
            else if (m_mode == 2 && eoc && m_left > 0) m_left--;
        end
    end
    assign m_carry = (m_mode == 2 && m_left == 0);

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk(conv_start === m_start, "R3 start pulse", conv_start, m_start);
            chk(ready === m_carry, "R4 R5 R6 ready timing", ready, m_carry);
            if (conv_start === 1'b1) n_start++;
            if (ready === 1'b1) n_ready++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        start_req = 1'b1; cyc(1); start_req = 1'b0;
    endtask

    initial begin
        int s0, r0;
        cyc(4);
        chk(conv_start === 1'b0 && ready === 1'b0, "R1 reset outputs", conv_start, 0);
        rst_n = 1'b1;
        cyc(10);
        chk(n_start == 0, "R1 no start after reset", n_start, 0);

        // single short request
        s0 = n_start; r0 = n_ready;
        pulse(); cyc(40);
        chk(n_start - s0 == 1, "R2 one-clock request starts once", n_start - s0, 1);
        chk(n_ready - r0 == 1, "R6 one ready per conversion", n_ready - r0, 1);

        // request inside a running conversion is absorbed
        s0 = n_start;
        pulse(); cyc(6); pulse(); cyc(50);
        chk(n_start - s0 == 1, "R8 absorbed request", n_start - s0, 1);

        // offset sweep, including requests meeting the latch clear (R7)
        for (int off = 0; off < 26; off++) begin
            pulse(); cyc(off); pulse(); cyc(60);
        end
        chk(m_pend == 1'b0, "R7 latch idle after sweep", m_pend, 0);

        // held request gives continuous conversions
        s0 = n_start;
        start_req = 1'b1; cyc(150); start_req = 1'b0;
        chk(n_start - s0 >= 5, "R9 back-to-back starts", n_start - s0, 5);
        cyc(60);
        s0 = n_start; cyc(40);
        chk(n_start == s0, "R9 stops after release", n_start, s0);

        // eoc dip during the count window pauses the counter
        glitch_en = 1'b1; conv_len = 7;
        r0 = n_ready;
        pulse(); cyc(50);
        chk(n_ready - r0 == 1, "R5 dip still one ready", n_ready - r0, 1);
        glitch_en = 1'b0;

        // reset mid-conversion: no late ready
        r0 = n_ready;
        pulse(); cyc(8);
        rst_n = 1'b0; cyc(2);
        chk(conv_start === 1'b0 && ready === 1'b0, "R1 outputs in reset", ready, 0);
        rst_n = 1'b1; cyc(40);
        chk(n_ready == r0, "R1 no ready after reset", n_ready, r0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule